// File: doc/BRIEF.md
# Tone-Burst Sine Sample Generator

This block builds audio samples for a DAC on a shared serial link, one sample per strobe from a rate timer. A 32-bit phase accumulator steps through a 256-entry sine table. A scaled slice of a pseudo-random word is added to each table value as noise. The result is then shaped by a linear amplitude envelope that rises, holds and falls inside a burst window. The burst window repeats at a programmable period.

Each strobe yields one 16-bit command word with a one-cycle valid pulse. The DAC channel-select bits are already set in the word, so the word can go straight to a serial shifter. A marker output shows when a sample is in flight. It can drive a timing pin or gate the shifter. The frequency is set by the phase increment, which is frequency × 2^32 / sample rate. The burst length, repeat period and noise gain are static inputs that take effect on the next strobe.

Top module: `tone_burst_dds`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first strobe, `dac_valid_o` and `marker_o` are 0 and `dac_word_o` is 0. The phase accumulator, the sample counter and the amplitude all start at 0.
- R2: On every strobe, the phase accumulator adds `phase_inc_i` modulo 2^32. Bits 31:24 of the updated value select the table entry.
- R3: Table entry i equals 1024 + round(1000·sin(2πi/256)). Every entry lies between 24 and 2024.
- R4: The noise term is (`rand_i`[10:0] × g) >> 4, where g is `noise_gain_i` limited to a maximum of 16. The noise term is added to the table entry.
- R5: The sample counter c goes to c+1 on each strobe. If c+1 is not below `repeat_i`, it goes to 0 instead.
- R6: While c < `duration_i`, the amplitude is set as follows. For c < 256 it increases by 1 per strobe, capped at 256. For c ≥ 256 and c + 256 < `duration_i` it is 256. Otherwise it decreases by 1 per strobe, floored at 0. The new amplitude is the one applied to the current sample.
- R7: When c ≥ `duration_i`, the amplitude is set to 0 and the word is 0x3000.
- R8: In the burst, the word is the low 16 bits of ((table + noise) × amplitude) >> 8 (logical shift), OR-ed with 0x3000. Bits 13:12 are the DAC command bits.
- R9: `dac_valid_o` is high for exactly the third cycle after the strobe is sampled. `dac_word_o` holds its value until the next valid pulse.
- R10: `marker_o` is high from the cycle after the strobe until the cycle in which `dac_valid_o` rises, where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle sample strobe |
| phase_inc_i | input | 32 | Phase increment per sample |
| duration_i | input | 32 | Burst length in samples |
| repeat_i | input | 32 | Burst repeat period in samples |
| noise_gain_i | input | 8 | Noise gain, limited to 16 |
| rand_i | input | 32 | Pseudo-random word, sampled with the strobe |
| dac_word_o | output | 16 | DAC command word |
| dac_valid_o | output | 1 | One-cycle valid for dac_word_o |
| marker_o | output | 1 | Sample-in-flight marker |

## Verification
The bench checks the envelope edges: the last rise step, the first hold sample at c = 256, and the change to the fall at c + 256 = duration. A wrong comparison there shifts the hold by one sample and makes the word off by a few LSBs. Short bursts below 256 samples and bursts shorter than 512 samples never reach the hold phase; a design that forced a hold would jump the amplitude to 256. Gains above 16 must give the same output as 16; a design without the limit overflows the noise term. The counter is checked at the wrap and in the silent tail, where a wrong design would emit stale samples instead of the bare 0x3000 prefix. A constant-phase run gives words that are multiples of four of the amplitude. A table sweep checks every table entry.

// File: rtl/tone_burst_pkg.sv
package tone_burst_pkg;

  // Rounded, offset sine value for table slot i of n.
  function automatic int sine_entry(int i, int n, int offset, int peak);
    real r;
    r = real'(peak) * $sin(2.0 * 3.14159265358979 * real'(i) / real'(n));
    if (r >= 0.0) sine_entry = offset + $rtoi(r + 0.5);
    else          sine_entry = offset - $rtoi(0.5 - r);
  endfunction

endpackage

// File: rtl/tbd_sine_rom.sv
module tbd_sine_rom #(
  parameter int AW     = 8,
  parameter int TW     = 12,
  parameter int OFFSET = 1024,
  parameter int PEAK   = 1000
) (
  input  logic [AW-1:0] idx_i,
  output logic [TW-1:0] val_o
);
  import tone_burst_pkg::*;
  localparam int DEPTH = 2 ** AW;

  logic [TW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int V = sine_entry(i, DEPTH, OFFSET, PEAK);
    assign rom[i] = TW'(V);
  end

  assign val_o = rom[idx_i];
endmodule

// File: rtl/tbd_env_ctrl.sv
module tbd_env_ctrl #(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int GW   = 8,
  parameter int NB   = 11,
  parameter int GMAX = 16,
  parameter int RAMP = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [DW-1:0] inc_i,
  input  logic [DW-1:0] dur_i,
  input  logic [DW-1:0] rep_i,
  input  logic [GW-1:0] gain_i,
  input  logic [DW-1:0] rand_i,
  output logic          s1_vld_o,
  output logic          s1_active_o,
  output logic [AW-1:0] s1_idx_o,
  output logic [DW-1:0] s1_noise_o,
  output logic [DW-1:0] s1_amp_o,
  output logic [DW-1:0] amp_o,
  output logic [DW-1:0] cnt_o
);
  localparam int GSH = $clog2(GMAX);
  localparam logic [DW-1:0] RAMP_V = DW'(RAMP);

  logic [DW-1:0] acc_q, cnt_q, amp_q;
  logic [DW-1:0] acc_nx, cnt_nx, amp_nx, noise;
  logic [DW:0]   cnt_p1;
  logic [GW-1:0] gain_c;
  logic          active, in_hold;
  logic          unused_rand;

  assign unused_rand = ^rand_i[DW-1:NB];

  always_comb begin
    acc_nx  = acc_q + inc_i;
    active  = cnt_q < dur_i;
    cnt_p1  = {1'b0, cnt_q} + (DW+1)'(1);
    cnt_nx  = (cnt_p1 < {1'b0, rep_i}) ? cnt_p1[DW-1:0] : '0;
    in_hold = ({1'b0, cnt_q} + (DW+1)'(RAMP)) < {1'b0, dur_i};
    gain_c  = (gain_i > GW'(GMAX)) ? GW'(GMAX) : gain_i;
    noise   = (DW'(rand_i[NB-1:0]) * DW'(gain_c)) >> GSH;
    if (!active)              amp_nx = '0;
    else if (cnt_q < RAMP_V)  amp_nx = (amp_q >= RAMP_V) ? RAMP_V : amp_q + 1'b1;
    else if (in_hold)         amp_nx = RAMP_V;
    else                      amp_nx = (amp_q == '0) ? '0 : amp_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      amp_q       <= '0;
      s1_vld_o    <= 1'b0;
      s1_active_o <= 1'b0;
      s1_idx_o    <= '0;
      s1_noise_o  <= '0;
      s1_amp_o    <= '0;
    end else begin
      s1_vld_o <= sample_i;
      if (sample_i) begin
        acc_q       <= acc_nx;
        cnt_q       <= cnt_nx;
        amp_q       <= amp_nx;
        s1_active_o <= active;
        s1_idx_o    <= acc_nx[DW-1 -: AW];
        s1_noise_o  <= noise;
        s1_amp_o    <= amp_nx;
      end
    end
  end

  assign amp_o = amp_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tbd_mix.sv
module tbd_mix #(
  parameter int          DW     = 32,
  parameter int          AW     = 8,
  parameter int          TW     = 12,
  parameter int          OW     = 16,
  parameter int          RAMP   = 256,
  parameter logic [15:0] PREFIX = 16'h3000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s1_vld_i,
  input  logic          s1_active_i,
  input  logic [AW-1:0] s1_idx_i,
  input  logic [DW-1:0] s1_noise_i,
  input  logic [DW-1:0] s1_amp_i,
  output logic          s2_vld_o,
  output logic [OW-1:0] word_o,
  output logic          word_vld_o
);
  localparam int SH = $clog2(RAMP);

  logic [TW-1:0] tbl_val;
  logic [DW-1:0] s2_sum, s2_amp, prod, prod_sh;
  logic          s2_active;
  logic          unused_hi;

  tbd_sine_rom #(.AW(AW), .TW(TW)) rom_i (
    .idx_i (s1_idx_i),
    .val_o (tbl_val)
  );

  assign prod      = s2_sum * s2_amp;
  assign prod_sh   = prod >> SH;
  assign unused_hi = ^prod_sh[DW-1:OW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_o   <= 1'b0;
      s2_active  <= 1'b0;
      s2_sum     <= '0;
      s2_amp     <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      s2_vld_o   <= s1_vld_i;
      word_vld_o <= s2_vld_o;
      if (s1_vld_i) begin
        s2_sum    <= DW'(tbl_val) + s1_noise_i;
        s2_amp    <= s1_amp_i;
        s2_active <= s1_active_i;
      end
      if (s2_vld_o)
        word_o <= s2_active ? (prod_sh[OW-1:0] | OW'(PREFIX)) : OW'(PREFIX);
    end
  end
endmodule

// File: rtl/tone_burst_dds.sv
module tone_burst_dds #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int GW = 8,
  parameter int OW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [DW-1:0] phase_inc_i,
  input  logic [DW-1:0] duration_i,
  input  logic [DW-1:0] repeat_i,
  input  logic [GW-1:0] noise_gain_i,
  input  logic [DW-1:0] rand_i,
  output logic [OW-1:0] dac_word_o,
  output logic          dac_valid_o,
  output logic          marker_o
);
  logic          s1_vld, s1_active, s2_vld;
  logic [AW-1:0] s1_idx;
  logic [DW-1:0] s1_noise, s1_amp, amp_q, cnt_q;
  logic          marker_q;

  tbd_env_ctrl #(.DW(DW), .AW(AW), .GW(GW)) env_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .inc_i       (phase_inc_i),
    .dur_i       (duration_i),
    .rep_i       (repeat_i),
    .gain_i      (noise_gain_i),
    .rand_i      (rand_i),
    .s1_vld_o    (s1_vld),
    .s1_active_o (s1_active),
    .s1_idx_o    (s1_idx),
    .s1_noise_o  (s1_noise),
    .s1_amp_o    (s1_amp),
    .amp_o       (amp_q),
    .cnt_o       (cnt_q)
  );

  tbd_mix #(.DW(DW), .AW(AW), .OW(OW)) mix_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s1_vld_i    (s1_vld),
    .s1_active_i (s1_active),
    .s1_idx_i    (s1_idx),
    .s1_noise_i  (s1_noise),
    .s1_amp_i    (s1_amp),
    .s2_vld_o    (s2_vld),
    .word_o      (dac_word_o),
    .word_vld_o  (dac_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       marker_q <= 1'b0;
    else if (sample_i) marker_q <= 1'b1;
    else if (s2_vld)   marker_q <= 1'b0;
  end

  assign marker_o = marker_q;
endmodule

// File: rtl/tone_burst_dds_chk.sv
module tone_burst_dds_chk #(
  parameter int DW = 32,
  parameter int OW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_i,
  input logic [DW-1:0] repeat_i,
  input logic [OW-1:0] dac_word_o,
  input logic          dac_valid_o,
  input logic          marker_o,
  input logic          s1_vld,
  input logic          s1_active,
  input logic [DW-1:0] amp_q,
  input logic [DW-1:0] cnt_q
);
  p_prefix_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |-> dac_word_o[15:12] == 4'h3);

  p_valid_after_marker_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_valid_o) |-> $past(marker_o));

  p_marker_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(marker_o) |-> $past(sample_i));

  p_amp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_q <= DW'(256));

  p_silent_amp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && !s1_active) |-> amp_q == '0);

  p_cnt_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && $stable(repeat_i)) |-> (cnt_q < repeat_i || cnt_q == '0));

  p_word_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_valid_o && !$past(dac_valid_o)) |-> $stable(dac_word_o));
endmodule

bind tone_burst_dds tone_burst_dds_chk #(.DW(DW), .OW(OW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .repeat_i    (repeat_i),
  .dac_word_o  (dac_word_o),
  .dac_valid_o (dac_valid_o),
  .marker_o    (marker_o),
  .s1_vld      (s1_vld),
  .s1_active   (s1_active),
  .amp_q       (amp_q),
  .cnt_q       (cnt_q)
);

// File: tb/tone_burst_dds_tb_top.sv
module tone_burst_dds_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_i = 1'b0;
  logic [31:0] phase_inc_i = '0, duration_i = '0, repeat_i = '0, rand_i = '0;
  logic [7:0]  noise_gain_i = '0;
  logic [15:0] dac_word_o;
  logic        dac_valid_o, marker_o;

  int checks = 0, failures = 0;
  int tbl [256];
  logic [31:0] m_acc, m_cnt, m_amp;

  always #2 clk_i = ~clk_i;

  tone_burst_dds dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sample_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", 32'(dac_valid_o), 0);
    chk("R1 marker in reset", 32'(marker_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 word after reset", 32'(dac_word_o), 0);
    m_acc = 0; m_cnt = 0; m_amp = 0;
  endtask

  // Reference model of one sample (R2..R8)
  function automatic logic [31:0] model(logic [31:0] r);
    logic [31:0] g, nz, s, w;
    m_acc = m_acc + phase_inc_i;                         // R2
    g  = (noise_gain_i > 16) ? 32'd16 : 32'(noise_gain_i);
    nz = ((r & 32'h7FF) * g) >> 4;                       // R4
    if (m_cnt < duration_i) begin
      s = 32'(tbl[m_acc[31:24]]) + nz;                   // R3
      if (m_cnt < 256)                  m_amp = (m_amp >= 256) ? 32'd256 : m_amp + 1;
      else if (m_cnt + 256 < duration_i) m_amp = 256;    // R6
      else                              m_amp = (m_amp == 0) ? 0 : m_amp - 1;
      w = (((s * m_amp) >> 8) & 32'hFFFF) | 32'h3000;    // R8
    end else begin
      m_amp = 0;
      w = 32'h3000;                                      // R7
    end
    m_cnt = (m_cnt + 1 < repeat_i) ? m_cnt + 1 : 0;      // R5
    return w;
  endfunction

  task automatic do_sample(string tag, logic [31:0] r);
    logic [31:0] exp;
    string t;
    t = (m_cnt < duration_i) ? {tag, " R8"} : {tag, " R7"};
    exp = model(r);
    @(negedge clk_i); sample_i = 1'b1; rand_i = r;
    @(negedge clk_i); sample_i = 1'b0;
    chk("R10 marker set", 32'(marker_o), 1);
    chk("R9 valid early", 32'(dac_valid_o), 0);
    @(negedge clk_i);
    chk("R9 valid early", 32'(dac_valid_o), 0);
    @(negedge clk_i);
    chk("R9 valid", 32'(dac_valid_o), 1);
    chk("R10 marker clear", 32'(marker_o), 0);
    chk(t, 32'(dac_word_o), exp);
    @(negedge clk_i);
    chk("R9 single pulse", 32'(dac_valid_o), 0);
    chk("R9 word hold", 32'(dac_word_o), exp);
  endtask

  task automatic run(string tag, logic [31:0] inc, logic [31:0] dur, logic [31:0] rep,
                     logic [7:0] gain, int n, bit rnd);
    phase_inc_i = inc; duration_i = dur; repeat_i = rep; noise_gain_i = gain;
    do_reset();
    for (int i = 0; i < n; i++) do_sample(tag, rnd ? $urandom() : 32'h0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin
      real v;
      v = 1000.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 256.0);
      tbl[i] = (v >= 0.0) ? 1024 + $rtoi(v + 0.5) : 1024 - $rtoi(0.5 - v);
    end
    // R6: constant phase, slot 0 = 1024, word = 4*amplitude | 0x3000
    run("R6 envelope", 32'h0, 600, 650, 8'd0, 700, 1'b0);
    // R3: step one table slot per sample across the hold phase
    run("R3 table sweep", 32'h0100_0000, 900, 900, 8'd0, 600, 1'b0);
    // R4: gain above 16 limited; R5 wrap at 380
    run("R4 gain clamp", 32'h0123_4567, 300, 380, 8'd200, 800, 1'b1);
    // R6: short burst never reaching hold; R2 odd increment
    run("R2 short burst", 32'h3FFF_FFFF, 100, 120, 8'd16, 300, 1'b1);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] d;
      d = 50 + ($urandom() % 650);
      run("R5 random", $urandom(), d, d + ($urandom() % 200), 8'($urandom() % 32), 400, 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++; failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule